// File: doc/BRIEF.md
# Paged Open-Drain GPIO Controller

This block is a 48-line bidirectional digital I/O controller behind a byte-wide host bus. Six 8-bit port registers drive the pins in open-drain style: a 1 makes a pin sink current and pull it low, and a 0 releases it so an external pull-up holds it high and it can be used as an input. When a port is read, the host sees the inverted pin level, taken through a two-flop synchronizer.

A page/lock register chooses which of three banks is visible at the three highest offsets. The banks are polarity, enable and interrupt ID. The port registers are visible on every page. Each port also has a lock bit that blocks host writes to it.

Polarity and enable bytes go out to a separate edge-capture unit, together with the synchronized pin levels. That unit returns its latched interrupt IDs and a pending summary, and this block reads both back to the host. When the host writes zero to an ID byte, this block sends the unit a one-cycle clear strobe for that byte.

Top module: `gpio_paged_ctrl`

## Requirements
- R1: A write to offsets 0x00 to 0x05 loads port register 0 to 5 whatever the page. `pad_drive_low` bits [8p+7:8p] equal port register p from the clock edge that takes the write (1 means sink and drive low).
- R2: A read of port offset p returns the bitwise inverse of pins [8p+7:8p] after a two-stage synchronizer. A pin change seen at the pads before edge k is returned by a read taken at edge k+2, but not by a read taken at edge k+1.
- R3: A read of offset 0x06 returns `cap_pending[2:0]` in bits 2:0 and zero in bits 7:3.
- R4: Offset 0x07 is the page/lock register. It can be read and written on any page. Bits 7:6 are the page: 0 means none, 1 polarity, 2 enable, 3 ID. Bit p (p = 0..5) locks port p.
- R5: On page 1, offsets 0x08, 0x09 and 0x0A read and write polarity bytes 0, 1 and 2, which drive `edge_pol` bits [7:0], [15:8] and [23:16].
- R6: On page 2 the same offsets read and write enable bytes 0 to 2, which drive `edge_en`. A write on one page leaves the other bank unchanged.
- R7: On page 3, offsets 0x08 to 0x0A read `cap_id` bytes 0 to 2. Writing 0x00 to such an offset raises `id_clr_stb[b]` for exactly one cycle. Writing a nonzero value raises no strobe.
- R8: While lock bit p is set, writes to port p are ignored. Reads of port p still return the pin level.
- R9: Offsets 0x0B to 0x0F on any page, and offsets 0x08 to 0x0A on page 0, read as 0x00, and writes to them change no register.
- R10: Synchronous reset clears the port, polarity, enable and page/lock registers and `bus_rdata`, so every pin starts released. It also resets the edge-capture unit's ID latches, which share the same reset.
- R11: `bus_rdata` is registered. It updates on the clock edge after `bus_rd` is high and holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 48 | Raw pin levels (1 = high) |
| pad_drive_low | output | 48 | Per-pin sink enable (1 = pull low) |
| pin_sync | output | 48 | Synchronized pin levels for edge capture |
| edge_pol | output | 24 | Polarity bytes to edge-capture unit |
| edge_en | output | 24 | Enable bytes to edge-capture unit |
| id_clr_stb | output | 3 | One-cycle clear strobe per ID byte |
| cap_id | input | 24 | Latched interrupt IDs from edge-capture unit |
| cap_pending | input | 8 | Pending summary from edge-capture unit |

## Verification
The bench checks the synchronizer depth by reading a port on three consecutive cycles after an external pin is pulled low. A design with a single sync stage would return the new level one read too early. It writes to a locked port and then reads the port back. A design that ignored the lock would start sinking those pins.

The bench also writes both zero and a nonzero value to an ID byte. A design that cleared on any write would lose the ID that must survive the nonzero write. It reads the banked offsets on page 0 and the offsets above the window, with nonzero bits placed under them. A decoder that ignored the page, or folded the address, would leak polarity data or pending bits into those reads.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_EN   = 2'd2,
    PG_ID   = 2'd3
  } page_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 48,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  // reset to all-high: a released open-drain pin idles high
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '1;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int NUM_PORTS = 6,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [PORT_W-1:0]           wdata,
  input  logic [NUM_PORTS-1:0]        lock,
  output logic [NUM_PORTS*PORT_W-1:0] drive
);
  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [PORT_W-1:0] port_q;
      logic              hit;
      assign hit = wr_en && (wr_addr == ADDR_W'(p)) && !lock[p];
      always_ff @(posedge clk) begin
        if (rst)      port_q <= '0;
        else if (hit) port_q <= wdata;
      end
      assign drive[p*PORT_W +: PORT_W] = port_q;
    end
  endgenerate
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_pkg::*;
#(
  parameter int BYTES  = 3,
  parameter int W      = 8,
  parameter int ADDR_W = 4,
  parameter int BASE   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [W-1:0]         wdata,
  input  page_e                page,
  output logic [BYTES*W-1:0]   pol,
  output logic [BYTES*W-1:0]   en,
  output logic [BYTES-1:0]     clr_stb
);
  generate
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      logic [W-1:0] pol_q, en_q;
      logic         clr_q;
      logic         hit;
      assign hit = wr_en && (wr_addr == ADDR_W'(BASE + b));
      always_ff @(posedge clk) begin
        if (rst) begin
          pol_q <= '0;
          en_q  <= '0;
          clr_q <= 1'b0;
        end else begin
          if (hit && page == PG_POL) pol_q <= wdata;
          if (hit && page == PG_EN)  en_q  <= wdata;
          clr_q <= hit && (page == PG_ID) && (wdata == '0);
        end
      end
      assign pol[b*W +: W] = pol_q;
      assign en[b*W +: W]  = en_q;
      assign clr_stb[b]    = clr_q;
    end
  endgenerate
endmodule

// File: rtl/gpio_paged_ctrl.sv
module gpio_paged_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PORTS   = 6,
  parameter int PORT_W      = 8,
  parameter int BANK_BYTES  = 3,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4,
  parameter int PEND_BITS   = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic                            bus_wr,
  input  logic [PORT_W-1:0]               bus_wdata,
  input  logic                            bus_rd,
  output logic [PORT_W-1:0]               bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0]     pad_in,
  output logic [NUM_PORTS*PORT_W-1:0]     pad_drive_low,
  output logic [NUM_PORTS*PORT_W-1:0]     pin_sync,
  output logic [BANK_BYTES*PORT_W-1:0]    edge_pol,
  output logic [BANK_BYTES*PORT_W-1:0]    edge_en,
  output logic [BANK_BYTES-1:0]           id_clr_stb,
  input  logic [BANK_BYTES*PORT_W-1:0]    cap_id,
  input  logic [PORT_W-1:0]               cap_pending
);
  localparam int PINS     = NUM_PORTS * PORT_W;
  localparam int OFF_PEND = NUM_PORTS;
  localparam int OFF_PGLK = NUM_PORTS + 1;
  localparam int OFF_BANK = NUM_PORTS + 2;
  localparam logic [PORT_W-1:0] PEND_MASK = PORT_W'((1 << PEND_BITS) - 1);

  logic [PORT_W-1:0] pglk_q;
  page_e             page;
  logic [PORT_W-1:0] rd_next;

  assign page = page_e'(pglk_q[PORT_W-1 -: 2]);

  always_ff @(posedge clk) begin
    if (rst)                                            pglk_q <= '0;
    else if (bus_wr && bus_addr == ADDR_W'(OFF_PGLK))   pglk_q <= bus_wdata;
  end

  gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
  );

  gpio_port_bank #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_ports (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .wr_addr(bus_addr), .wdata(bus_wdata),
    .lock(pglk_q[NUM_PORTS-1:0]), .drive(pad_drive_low)
  );

  gpio_bank_regs #(.BYTES(BANK_BYTES), .W(PORT_W), .ADDR_W(ADDR_W), .BASE(OFF_BANK)) u_bank (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .wr_addr(bus_addr), .wdata(bus_wdata),
    .page(page), .pol(edge_pol), .en(edge_en), .clr_stb(id_clr_stb)
  );

  always_comb begin
    rd_next = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (bus_addr == ADDR_W'(p)) rd_next = ~pin_sync[p*PORT_W +: PORT_W];
    end
    if (bus_addr == ADDR_W'(OFF_PEND)) rd_next = cap_pending & PEND_MASK;
    if (bus_addr == ADDR_W'(OFF_PGLK)) rd_next = pglk_q;
    for (int b = 0; b < BANK_BYTES; b++) begin
      if (bus_addr == ADDR_W'(OFF_BANK + b)) begin
        case (page)
          PG_POL:  rd_next = edge_pol[b*PORT_W +: PORT_W];
          PG_EN:   rd_next = edge_en[b*PORT_W +: PORT_W];
          PG_ID:   rd_next = cap_id[b*PORT_W +: PORT_W];
          default: rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/gpio_paged_ctrl_chk.sv
module gpio_paged_ctrl_chk #(
  parameter int NUM_PORTS  = 6,
  parameter int PORT_W     = 8,
  parameter int BANK_BYTES = 3,
  parameter int ADDR_W     = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic                         bus_wr,
  input logic [PORT_W-1:0]            bus_wdata,
  input logic                         bus_rd,
  input logic [PORT_W-1:0]            bus_rdata,
  input logic [NUM_PORTS*PORT_W-1:0]  pad_drive_low,
  input logic [BANK_BYTES*PORT_W-1:0] edge_pol,
  input logic [BANK_BYTES*PORT_W-1:0] edge_en,
  input logic [BANK_BYTES-1:0]        id_clr_stb,
  input logic [PORT_W-1:0]            pglk
);
  localparam int OFF_PEND = NUM_PORTS;
  localparam int OFF_BANK = NUM_PORTS + 2;
  localparam int OFF_TOP  = OFF_BANK + BANK_BYTES;

  logic [1:0] pg;
  logic       locked_wr;
  logic       zero_rd;

  assign pg = pglk[PORT_W-1 -: 2];

  always_comb begin
    locked_wr = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (bus_wr && bus_addr == ADDR_W'(p) && pglk[p]) locked_wr = 1'b1;
  end

  assign zero_rd = bus_rd && ((bus_addr >= ADDR_W'(OFF_TOP)) ||
                              (bus_addr >= ADDR_W'(OFF_BANK) && pg == 2'd0));

  p_lock_hold_r8: assert property (@(posedge clk) disable iff (rst)
    locked_wr |=> $stable(pad_drive_low));

  p_clr_source_r7: assert property (@(posedge clk) disable iff (rst)
    (id_clr_stb != '0) |-> $past(bus_wr && bus_wdata == '0 && pg == 2'd3));

  p_clr_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(id_clr_stb));

  p_pend_mask_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFF_PEND)) |=> (bus_rdata[PORT_W-1:3] == '0));

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (rst)
    zero_rd |=> (bus_rdata == '0));

  p_bank_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> ($stable(edge_pol) && $stable(edge_en)));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  p_rst_clear_r10: assert property (@(posedge clk)
    rst |=> (pad_drive_low == '0 && edge_en == '0 && edge_pol == '0));
endmodule

bind gpio_paged_ctrl gpio_paged_ctrl_chk #(
  .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .BANK_BYTES(BANK_BYTES), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pad_drive_low(pad_drive_low),
  .edge_pol(edge_pol), .edge_en(edge_en), .id_clr_stb(id_clr_stb), .pglk(pglk_q)
);

// File: tb/test_gpio_paged_ctrl.sv
module test_gpio_paged_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [47:0] pad_in, pad_drive_low, pin_sync, ext_low = '0;
  logic [23:0] edge_pol, edge_en, cap_id, id_set = '0, clr_mask;
  logic [2:0]  id_clr_stb;
  logic [7:0]  cap_pending = '0;
  int          n_checks = 0, n_errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // open-drain wire: low if the block or an external source sinks it
  assign pad_in = ~(pad_drive_low | ext_low);

  // edge-capture unit stand-in: holds IDs, clears a byte on its strobe
  always_comb for (int b = 0; b < 3; b++) clr_mask[b*8 +: 8] = {8{id_clr_stb[b]}};
  always @(posedge clk) begin
    if (rst) cap_id <= '0;
    else     cap_id <= (cap_id | id_set) & ~clr_mask;
  end

  gpio_paged_ctrl i_gpio_paged_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_drive_low(pad_drive_low),
    .pin_sync(pin_sync), .edge_pol(edge_pol), .edge_en(edge_en), .id_clr_stb(id_clr_stb),
    .cap_id(cap_id), .cap_pending(cap_pending)
  );

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R10 drive after reset", pad_drive_low, 48'h0);
    check("R10 pol/en after reset", {edge_pol, edge_en}, 48'h0);
    check("R10 rdata after reset", bus_rdata, 8'h00);
    rd(4'h7, d); check("R10 page/lock after reset", d, 8'h00);
    rd(4'h0, d); check("R2 released pin reads 0", d, 8'h00);
  endtask

  task automatic t_ports();
    logic [7:0] d;
    wr(4'h2, 8'hA5);
    check("R1 port2 drive", pad_drive_low, 48'h0000_00A5_0000);
    settle();
    rd(4'h2, d); check("R2 port2 readback", d, 8'hA5);
    wr(4'h7, 8'h80);
    wr(4'h4, 8'h3C);
    check("R1 port4 write on page 2", pad_drive_low[39:32], 8'h3C);
    wr(4'h7, 8'hC0);
    wr(4'h0, 8'h01);
    check("R1 port0 write on page 3", pad_drive_low[7:0], 8'h01);
  endtask

  task automatic t_input();
    logic [7:0] d0, d1, d2;
    ext_low[47:40] = 8'h81;
    rd(4'h5, d0);
    rd(4'h5, d1);
    rd(4'h5, d2);
    check("R2 sync edge+1", d0, 8'h00);
    check("R2 sync edge+2 still old", d1, 8'h00);
    check("R2 sync edge+3 new level", d2, 8'h81);
    repeat (2) @(negedge clk);
    check("R11 rdata held without read", bus_rdata, 8'h81);
    ext_low = '0;
  endtask

  task automatic t_lock();
    logic [7:0] d;
    wr(4'h7, 8'h10);
    rd(4'h7, d); check("R4 page/lock readback", d, 8'h10);
    wr(4'h4, 8'hFF);
    check("R8 locked port4 unchanged", pad_drive_low[39:32], 8'h3C);
    settle();
    rd(4'h4, d); check("R8 locked port4 still readable", d, 8'h3C);
    wr(4'h3, 8'h11);
    check("R8 unlocked port3 writes", pad_drive_low[31:24], 8'h11);
  endtask

  task automatic t_banks();
    logic [7:0] d;
    wr(4'h7, 8'h40);
    wr(4'h8, 8'h12); wr(4'h9, 8'h34); wr(4'hA, 8'h56);
    check("R5 polarity bytes", edge_pol, 24'h563412);
    rd(4'h9, d); check("R5 polarity byte1 read", d, 8'h34);
    wr(4'h7, 8'h80);
    wr(4'hA, 8'h9A);
    check("R6 enable byte2", edge_en, 24'h9A0000);
    check("R6 polarity untouched by page 2", edge_pol, 24'h563412);
    rd(4'h8, d); check("R6 enable byte0 read", d, 8'h00);
  endtask

  task automatic t_pending();
    logic [7:0] d;
    cap_pending = 8'hFD;
    rd(4'h6, d); check("R3 pending masked", d, 8'h05);
    cap_pending = '0;
  endtask

  task automatic t_ids();
    logic [7:0] d;
    wr(4'h7, 8'hC0);
    id_set = 24'hABCDEF;
    @(negedge clk);
    id_set = '0;
    rd(4'h8, d); check("R7 id byte0", d, 8'hEF);
    rd(4'hA, d); check("R7 id byte2", d, 8'hAB);
    wr(4'h9, 8'h55);
    @(negedge clk);
    rd(4'h9, d); check("R7 nonzero write keeps id", d, 8'hCD);
    wr(4'h9, 8'h00);
    @(negedge clk);
    rd(4'h9, d); check("R7 zero write clears byte1", d, 8'h00);
    rd(4'h8, d); check("R7 byte0 survives", d, 8'hEF);
  endtask

  task automatic t_unused();
    logic [7:0] d;
    logic [47:0] drv;
    wr(4'h7, 8'h00);
    rd(4'h8, d); check("R9 page0 bank offset reads 0", d, 8'h00);
    wr(4'h8, 8'hFF);
    cap_pending = 8'h07;
    rd(4'hE, d); check("R9 offset 0xE reads 0", d, 8'h00);
    drv = pad_drive_low;
    wr(4'hD, 8'hFF);
    wr(4'h7, 8'h40);
    wr(4'hB, 8'hFF);
    check("R9 unused writes leave ports", pad_drive_low, drv);
    check("R9 unused writes leave banks", {edge_pol, edge_en}, {24'h563412, 24'h9A0000});
    rd(4'h8, d); check("R9 page0 write did not reach pol", d, 8'h12);
    cap_pending = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ports();
    t_input();
    t_lock();
    t_banks();
    t_pending();
    t_ids();
    t_unused();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule